// File: doc/BRIEF.md
# BCD Alarm Comparator with Repeat Modes

This block sits beside a real-time calendar and decides when its alarm goes off. Each second the calendar presents fresh BCD values for seconds, minutes, hours and day-of-month together with a one-cycle update strobe. The block compares those values against four programmed alarm bytes. The top bit of each alarm byte does not hold part of the alarm value. Taken together, these four bits form a repeat code. The code selects which fields take part in the comparison, so the alarm can fire every second, minute, hour or day, or once a month.

A match sets a sticky alarm flag. The flag drives an interrupt request when the flag enable is on. While the system runs from its backup supply, the request also needs the backup-alarm enable. Software clears the flag and releases the request by reading the flags register. That read only counts when the read qualifier stays high for a programmable number of consecutive clocks. The block also presents the flags byte. That byte merges the alarm flag with the watchdog and battery-low flags that other logic supplies.

Top module: `alarm_match_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `alarm_flag_o`, `irq_o` and `flags_o` are all zero.
- R2: The repeat code is {date[7], hour[7], min[7], sec[7]} taken from the alarm bytes. Code 1111 compares no field, 1110 compares seconds only, 1100 compares seconds and minutes, 1000 compares seconds, minutes and hours, and 0000 compares all four fields.
- R3: Any other repeat code compares no field, so the alarm fires on every update strobe.
- R4: Seconds and minutes are compared on bits 6..0. Hours and date are compared on bits 5..0. Bit 7 of the current seconds value (the stop bit) and bit 6 of the hour and date alarm bytes are ignored.
- R5: The flag is set on the clock edge where `tick_i` is high and the selected fields match. Without a strobe, equal fields never set it, however long they stay equal.
- R6: `irq_o` is registered. It is high one edge after the flag is set or is already set, provided `flag_en_i` is high at that edge. It drops on the edge after `flag_en_i` falls.
- R7: While `bkup_i` is high, `irq_o` also requires `bkup_en_i`. The flag itself is set regardless of either enable.
- R8: The flag and `irq_o` clear on the edge of the RD_HOLD-th consecutive cycle with `flag_rd_i` high. A shorter run of read cycles has no effect.
- R9: If a match coincides with the clearing edge of a qualified read, the flag stays set.
- R10: `flags_o` is registered: bit 7 = `wdog_flag_i`, bit 6 = alarm flag, bit 4 = `batt_low_i`, and bits 5 and 3..0 are zero. Bit 6 always equals `alarm_flag_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| tick_i | input | 1 | One-cycle strobe marking fresh time values |
| cur_sec_i | input | 8 | Current seconds, BCD (bit 7 ignored) |
| cur_min_i | input | 8 | Current minutes, BCD |
| cur_hr_i | input | 8 | Current hours, BCD |
| cur_date_i | input | 8 | Current day of month, BCD |
| alm_sec_i | input | 8 | Alarm seconds; bit 7 = repeat code bit 0 |
| alm_min_i | input | 8 | Alarm minutes; bit 7 = repeat code bit 1 |
| alm_hr_i | input | 8 | Alarm hours; bit 7 = repeat code bit 2 |
| alm_date_i | input | 8 | Alarm date; bit 7 = repeat code bit 3 |
| flag_en_i | input | 1 | Lets the alarm flag drive the request |
| bkup_i | input | 1 | System is running on backup supply |
| bkup_en_i | input | 1 | Permits the request while on backup supply |
| flag_rd_i | input | 1 | Read of the flags register in progress |
| wdog_flag_i | input | 1 | Watchdog flag to merge into the flags byte |
| batt_low_i | input | 1 | Battery-low flag to merge into the flags byte |
| alarm_flag_o | output | 1 | Sticky alarm flag |
| irq_o | output | 1 | Active-high interrupt request |
| flags_o | output | 8 | Flags byte |

## Verification
The assertions check three things on every cycle. The request never appears without the flag. The request only appears when the flag enable was high, and the backup enable too while on backup supply. The flag rises only after an update strobe and falls only after a read. The assertions also check the flags byte layout. Only the bench scenarios can show which fields each repeat code actually compares, that invalid codes fall back to every-second firing, and that masked bits are ignored. The exact length of the read that clears the flag, and the set-over-clear priority, also need directed timing from the bench.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int BYTE_W = 8;
  localparam int NFIELD = 4;  // index 0 sec, 1 min, 2 hr, 3 date

  // Bits of each field that take part in the comparison
  function automatic logic [BYTE_W-1:0] field_mask(input int idx);
    return (idx < 2) ? 8'h7F : 8'h3F;
  endfunction

  // Repeat code -> per-field compare enables (bit i = field i)
  function automatic logic [NFIELD-1:0] cmp_enables(input logic [NFIELD-1:0] code);
    case (code)
      4'b1110: return 4'b0001;
      4'b1100: return 4'b0011;
      4'b1000: return 4'b0111;
      4'b0000: return 4'b1111;
      default: return 4'b0000;  // 1111 and all invalid codes: every second
    endcase
  endfunction
endpackage

// File: rtl/alm_compare.sv
module alm_compare
  import alm_pkg::*;
#(
  parameter int FIELDS = NFIELD
) (
  input  logic [FIELDS-1:0][BYTE_W-1:0] cur_i,
  input  logic [FIELDS-1:0][BYTE_W-1:0] alm_i,
  output logic                          hit_o
);
  logic [FIELDS-1:0] eq;
  logic [FIELDS-1:0] code;
  logic [FIELDS-1:0] use_f;

  for (genvar i = 0; i < FIELDS; i++) begin : g_field
    assign eq[i]   = ((cur_i[i] ^ alm_i[i]) & field_mask(i)) == '0;
    assign code[i] = alm_i[i][BYTE_W-1];
  end

  assign use_f = cmp_enables(code);
  assign hit_o = &(eq | ~use_f);
endmodule

// File: rtl/alm_rd_qual.sv
module alm_rd_qual #(
  parameter int HOLD = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_i,
  output logic clr_o
);
  localparam int CW = $clog2(HOLD + 1);
  logic [CW-1:0] cnt;

  // Fires once, on the HOLD-th consecutive read cycle
  assign clr_o = rd_i && (cnt == CW'(HOLD - 1));

  always_ff @(posedge clk) begin
    if (rst || !rd_i) cnt <= '0;
    else if (cnt != CW'(HOLD)) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/alm_flag_ctl.sv
module alm_flag_ctl (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic hit_i,
  input  logic clr_i,
  input  logic flag_en_i,
  input  logic bkup_i,
  input  logic bkup_en_i,
  output logic flag_nxt_o,
  output logic flag_o,
  output logic irq_o
);
  logic set_now;
  logic gate;

  assign set_now    = tick_i && hit_i;
  // set has priority over a coinciding clear
  assign flag_nxt_o = set_now || (flag_o && !clr_i);
  assign gate       = flag_en_i && (!bkup_i || bkup_en_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      flag_o <= flag_nxt_o;
      irq_o  <= flag_nxt_o && gate;
    end
  end
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alm_pkg::*;
#(
  parameter int RD_HOLD = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [BYTE_W-1:0] cur_sec_i,
  input  logic [BYTE_W-1:0] cur_min_i,
  input  logic [BYTE_W-1:0] cur_hr_i,
  input  logic [BYTE_W-1:0] cur_date_i,
  input  logic [BYTE_W-1:0] alm_sec_i,
  input  logic [BYTE_W-1:0] alm_min_i,
  input  logic [BYTE_W-1:0] alm_hr_i,
  input  logic [BYTE_W-1:0] alm_date_i,
  input  logic              flag_en_i,
  input  logic              bkup_i,
  input  logic              bkup_en_i,
  input  logic              flag_rd_i,
  input  logic              wdog_flag_i,
  input  logic              batt_low_i,
  output logic              alarm_flag_o,
  output logic              irq_o,
  output logic [BYTE_W-1:0] flags_o
);
  logic [NFIELD-1:0][BYTE_W-1:0] cur_v;
  logic [NFIELD-1:0][BYTE_W-1:0] alm_v;
  logic hit, clr, flag_nxt;

  assign cur_v = {cur_date_i, cur_hr_i, cur_min_i, cur_sec_i};
  assign alm_v = {alm_date_i, alm_hr_i, alm_min_i, alm_sec_i};

  alm_compare #(.FIELDS(NFIELD)) u_cmp (
    .cur_i(cur_v), .alm_i(alm_v), .hit_o(hit)
  );

  alm_rd_qual #(.HOLD(RD_HOLD)) u_rdq (
    .clk(clk), .rst(rst), .rd_i(flag_rd_i), .clr_o(clr)
  );

  alm_flag_ctl u_flag (
    .clk(clk), .rst(rst), .tick_i(tick_i), .hit_i(hit), .clr_i(clr),
    .flag_en_i(flag_en_i), .bkup_i(bkup_i), .bkup_en_i(bkup_en_i),
    .flag_nxt_o(flag_nxt), .flag_o(alarm_flag_o), .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) flags_o <= '0;
    else     flags_o <= {wdog_flag_i, flag_nxt, 1'b0, batt_low_i, 4'b0000};
  end
endmodule

// File: rtl/alarm_match_unit_chk.sv
module alarm_match_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_i,
  input logic       flag_en_i,
  input logic       bkup_i,
  input logic       bkup_en_i,
  input logic       flag_rd_i,
  input logic       alarm_flag_o,
  input logic       irq_o,
  input logic [7:0] flags_o
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!alarm_flag_o && !irq_o && flags_o == 8'h00));

  assert_rise_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_flag_o) |-> $past(tick_i));

  assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> alarm_flag_o);

  assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(flag_en_i));

  assert_backup_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_o && $past(bkup_i)) |-> $past(bkup_en_i));

  assert_fall_on_read_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(alarm_flag_o) |-> $past(flag_rd_i));

  assert_flags_layout_R10: assert property (@(posedge clk) disable iff (rst)
    (flags_o[6] == alarm_flag_o) && (flags_o[5] == 1'b0) && (flags_o[3:0] == 4'h0));
endmodule

bind alarm_match_unit alarm_match_unit_chk u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .flag_en_i(flag_en_i),
  .bkup_i(bkup_i), .bkup_en_i(bkup_en_i), .flag_rd_i(flag_rd_i),
  .alarm_flag_o(alarm_flag_o), .irq_o(irq_o), .flags_o(flags_o)
);

// File: tb/alarm_match_unit_bench.sv
module alarm_match_unit_bench;
  localparam int HOLD = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [7:0] cs = 8'h00, cm = 8'h00, ch = 8'h00, cd = 8'h01;
  logic [7:0] as_ = 8'h00, am = 8'h00, ah = 8'h00, ad = 8'h01;
  logic fen = 1'b0, bk = 1'b0, bken = 1'b0, rd = 1'b0, wdf = 1'b0, bl = 1'b0;
  logic flag, irq;
  logic [7:0] flags;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alarm_match_unit #(.RD_HOLD(HOLD)) u_alarm_match_unit (
    .clk(clk), .rst(rst), .tick_i(tick),
    .cur_sec_i(cs), .cur_min_i(cm), .cur_hr_i(ch), .cur_date_i(cd),
    .alm_sec_i(as_), .alm_min_i(am), .alm_hr_i(ah), .alm_date_i(ad),
    .flag_en_i(fen), .bkup_i(bk), .bkup_en_i(bken), .flag_rd_i(rd),
    .wdog_flag_i(wdf), .batt_low_i(bl),
    .alarm_flag_o(flag), .irq_o(irq), .flags_o(flags)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_time(input logic [7:0] s, m, h, d);
    cs = s; cm = m; ch = h; cd = d;
  endtask

  // code bit 0 -> sec byte, 1 -> min, 2 -> hr, 3 -> date
  task automatic set_alarm(input logic [3:0] code, input logic [6:0] s, m, h, d);
    as_ = {code[0], s}; am = {code[1], m}; ah = {code[2], h}; ad = {code[3], d};
  endtask

  task automatic pulse_tick;
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic clear_flag;
    @(negedge clk) rd = 1'b1;
    repeat (HOLD) @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic fire_expect(input logic exp, input string req);
    pulse_tick();
    check({7'd0, flag}, {7'd0, exp}, req);
    clear_flag();
  endtask

  task automatic t_reset;
    rst = 1'b1; fen = 1'b1;
    repeat (3) @(negedge clk);
    check({6'd0, flag, irq}, 8'h00, "R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check({6'd0, flag, irq}, 8'h00, "R1 after reset");
    check(flags, 8'h00, "R1 flags");
    fen = 1'b0;
  endtask

  task automatic t_modes;
    set_time(8'h12, 8'h34, 8'h15, 8'h20);
    set_alarm(4'b1111, 7'h55, 7'h01, 7'h02, 7'h03);
    fire_expect(1'b1, "R2 every second");
    set_alarm(4'b1110, 7'h12, 7'h00, 7'h00, 7'h00);
    fire_expect(1'b1, "R2 minute match");
    set_alarm(4'b1110, 7'h13, 7'h34, 7'h15, 7'h20);
    fire_expect(1'b0, "R2 minute miss");
    set_alarm(4'b1100, 7'h12, 7'h34, 7'h00, 7'h00);
    fire_expect(1'b1, "R2 hour match");
    set_alarm(4'b1100, 7'h12, 7'h35, 7'h15, 7'h20);
    fire_expect(1'b0, "R2 hour miss");
    set_alarm(4'b1000, 7'h12, 7'h34, 7'h15, 7'h01);
    fire_expect(1'b1, "R2 day match");
    set_alarm(4'b1000, 7'h12, 7'h34, 7'h16, 7'h20);
    fire_expect(1'b0, "R2 day miss");
    set_alarm(4'b0000, 7'h12, 7'h34, 7'h15, 7'h20);
    fire_expect(1'b1, "R2 month match");
    set_alarm(4'b0000, 7'h12, 7'h34, 7'h15, 7'h21);
    fire_expect(1'b0, "R2 month miss");
  endtask

  task automatic t_invalid;
    set_alarm(4'b1010, 7'h00, 7'h00, 7'h00, 7'h00);
    fire_expect(1'b1, "R3 code 1010");
    set_alarm(4'b0101, 7'h00, 7'h00, 7'h00, 7'h00);
    fire_expect(1'b1, "R3 code 0101");
  endtask

  task automatic t_masked;
    set_time(8'h92, 8'h34, 8'h15, 8'h20);  // stop bit set in seconds
    set_alarm(4'b0000, 7'h12, 7'h34, 7'h55, 7'h60);  // bit 6 set in hr/date
    fire_expect(1'b1, "R4 ignored bits");
    set_alarm(4'b0000, 7'h52, 7'h34, 7'h15, 7'h20);  // bit 6 of sec compared
    fire_expect(1'b0, "R4 sec bit 6 compared");
    set_time(8'h12, 8'h34, 8'h15, 8'h20);
  endtask

  task automatic t_strobe;
    set_alarm(4'b0000, 7'h12, 7'h34, 7'h15, 7'h20);
    repeat (5) @(negedge clk);
    check({7'd0, flag}, 8'h00, "R5 no strobe no set");
    pulse_tick();
    check({7'd0, flag}, 8'h01, "R5 strobe sets");
    clear_flag();
    repeat (5) @(negedge clk);
    check({7'd0, flag}, 8'h00, "R5 no re-set while equal");
  endtask

  task automatic t_irq;
    fen = 1'b0;
    pulse_tick();
    check({6'd0, flag, irq}, 8'h02, "R6 flag without enable");
    fen = 1'b1;
    @(negedge clk);
    check({7'd0, irq}, 8'h01, "R6 enable raises irq");
    fen = 1'b0;
    @(negedge clk);
    check({7'd0, irq}, 8'h00, "R6 enable drop");
    fen = 1'b1;
    clear_flag();
    check({6'd0, flag, irq}, 8'h00, "R6 irq released by read");
    fen = 1'b0;
  endtask

  task automatic t_backup;
    fen = 1'b1; bk = 1'b1; bken = 1'b0;
    pulse_tick();
    check({6'd0, flag, irq}, 8'h02, "R7 backup blocks irq");
    bken = 1'b1;
    @(negedge clk);
    check({7'd0, irq}, 8'h01, "R7 backup enable");
    clear_flag();
    fen = 1'b0; bk = 1'b0; bken = 1'b0;
  endtask

  task automatic t_read;
    pulse_tick();
    @(negedge clk) rd = 1'b1;
    repeat (HOLD - 1) @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
    check({7'd0, flag}, 8'h01, "R8 short read ignored");
    @(negedge clk) rd = 1'b1;
    repeat (HOLD) @(negedge clk);
    rd = 1'b0;
    check({7'd0, flag}, 8'h00, "R8 held read clears");
  endtask

  task automatic t_priority;
    pulse_tick();
    @(negedge clk) rd = 1'b1;
    repeat (HOLD - 1) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0; rd = 1'b0;
    check({7'd0, flag}, 8'h01, "R9 set beats clear");
    clear_flag();
  endtask

  task automatic t_flags;
    wdf = 1'b1; bl = 1'b1;
    @(negedge clk);
    check(flags, 8'h90, "R10 flags no alarm");
    pulse_tick();
    check(flags, 8'hD0, "R10 flags with alarm");
    wdf = 1'b0; bl = 1'b0;
    @(negedge clk);
    check(flags, 8'h40, "R10 flags alarm only");
    clear_flag();
  endtask

  initial begin
    t_reset();
    t_modes();
    t_invalid();
    t_masked();
    t_strobe();
    t_irq();
    t_backup();
    t_read();
    t_priority();
    t_flags();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule